// File: doc/BRIEF.md
# Dual Down-Counting Reloadable Timer

This block holds a parameterised set of down-counters (two by default, each 32 bits) behind a small synchronous register bus. Each counter has a writable live count and a writable reload value. One shared control word carries an enable bit and an auto-reload bit for every counter. A counter advances only in cycles where the `tick` strobe is high. Tying `tick` high makes it count on every clock; driving it from a divider gives a slower time base.

A counter that reaches zero and then sees another tick has expired. With auto-reload on, it takes its reload value and keeps running, so a period of N ticks needs N-1 in both the reload and the count registers. With auto-reload off, the counter stays at zero and its enable bit clears itself, so software sees from the control word that the one-shot has finished. Every expiry gives a one-cycle pulse on that timer's own `expire_o` bit and on the shared `irq_o` line.

Top module: `dual_tmr`

## Requirements
- R1: After reset, the control word, every count and every reload value read 0, and `expire_o` and `irq_o` are low.
- R2: The control word is at byte address 0x00. Timer i's enable bit is bit 2i and its auto-reload bit is bit 2i+1. Reading the word returns the bits last stored. Any address that is not mapped reads 0.
- R3: Timer i's reload value is at byte address 0x10+8i and its live count is at 0x14+8i. Both read back the last value written.
- R4: When a timer is enabled and `tick` is high at a clock edge, a nonzero count drops by exactly one. When `tick` is low, the count holds.
- R5: A timer whose enable bit is 0 keeps its count, whatever `tick` does.
- R6: With auto-reload on, a tick at count 0 loads the reload value, so the timer repeats every reload+1 ticks.
- R7: With auto-reload off, a tick at count 0 leaves the count at 0, clears that timer's enable bit and produces one expiry only.
- R8: `expire_o[i]` is high for the single cycle after the clock edge at which timer i expired. `irq_o` is high in exactly the cycles where any `expire_o` bit is high.
- R9: A bus write to a count register in the same cycle as a count step or a reload wins. The count then holds the written value and no expiry is produced.
- R10: A control write that changes only one timer's bits leaves the other timer counting with no lost or extra step.
- R11: A control write in the same cycle as a one-shot self-clear wins. The enable bit takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count strobe; counters step only when high |
| addr | input | ADDR_W (6) | Byte address of the register accessed |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | DATA_W (32) | Write data |
| rd_data | output | DATA_W (32) | Read data, combinational from address |
| expire_o | output | NUM_TIMERS (2) | Per-timer one-cycle expiry pulse |
| irq_o | output | 1 | Interrupt pulse, high when any timer expires |

## Verification
A wrong count shows up at once when the live count is read. It also moves every later expiry pulse by the same number of ticks, so a step that is missed or doubled is visible in the very next period. A reload taken from the wrong register changes the spacing between pulses after the first expiry. A self-clear that fails shows as a second pulse one tick after a one-shot ends, and as a stale enable bit in the control word. A priority mistake between a bus write and the counter shows in the count read back in the cycle right after that write.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

   localparam int CTRL_ADDR = 'h00;
   localparam int BANK_BASE = 'h10;
   localparam int BANK_STEP = 'h08;
   localparam int VAL_OFS   = 'h04;

   // byte address of timer i's reload register
   function automatic int rld_addr(input int i);
      return BANK_BASE + BANK_STEP * i;
   endfunction

   // byte address of timer i's live count register
   function automatic int val_addr(input int i);
      return BANK_BASE + BANK_STEP * i + VAL_OFS;
   endfunction

   function automatic int en_bit(input int i);
      return 2 * i;
   endfunction

   function automatic int rl_bit(input int i);
      return 2 * i + 1;
   endfunction

   typedef struct packed {
      logic run;
      logic autoload;
   } tmr_mode_t;

endpackage

// File: rtl/dtmr_decode.sv
module dtmr_decode
   import dtmr_pkg::*;
#(
   parameter int NUM_TIMERS = 2,
   parameter int ADDR_W     = 6
) (
   input  logic [ADDR_W-1:0]     addr,
   input  logic                  wr_en,
   output logic                  wr_ctrl,
   output logic [NUM_TIMERS-1:0] wr_rld,
   output logic [NUM_TIMERS-1:0] wr_val
);

   assign wr_ctrl = wr_en && (addr == ADDR_W'(CTRL_ADDR));

   for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_dec
      assign wr_rld[i] = wr_en && (addr == ADDR_W'(rld_addr(i)));
      assign wr_val[i] = wr_en && (addr == ADDR_W'(val_addr(i)));
   end

endmodule

// File: rtl/dtmr_ctrl.sv
module dtmr_ctrl
   import dtmr_pkg::*;
#(
   parameter int NUM_TIMERS = 2,
   parameter int DATA_W     = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_ctrl,
   input  logic [DATA_W-1:0]       wr_data,
   input  logic [NUM_TIMERS-1:0]   stop_req,
   output logic [2*NUM_TIMERS-1:0] ctrl_q,
   output tmr_mode_t               mode [NUM_TIMERS]
);

   localparam int CW = 2 * NUM_TIMERS;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         // a bus write overrides any self-clear in the same cycle
         ctrl_q <= wr_data[CW-1:0];
      end else begin
         for (int i = 0; i < NUM_TIMERS; i++) begin
            if (stop_req[i]) ctrl_q[en_bit(i)] <= 1'b0;
         end
      end
   end

   for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_mode
      assign mode[i].run      = ctrl_q[en_bit(i)];
      assign mode[i].autoload = ctrl_q[rl_bit(i)];
   end

endmodule

// File: rtl/dtmr_chan.sv
module dtmr_chan
   import dtmr_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  tmr_mode_t        mode,
   input  logic             wr_rld,
   input  logic             wr_val,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] rld_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic             expire_q,
   output logic             stop_req
);

   logic step;
   logic at_zero;
   logic hit;

   assign step     = mode.run && tick;
   assign at_zero  = (cnt_q == '0);
   assign hit      = step && at_zero && !wr_val;
   assign stop_req = hit && !mode.autoload;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rld_q    <= '0;
         cnt_q    <= '0;
         expire_q <= 1'b0;
      end else begin
         if (wr_rld) rld_q <= wdata;
         if (wr_val) begin
            cnt_q <= wdata;
         end else if (step) begin
            if (!at_zero)          cnt_q <= cnt_q - 1'b1;
            else if (mode.autoload) cnt_q <= rld_q;
         end
         expire_q <= hit;
      end
   end

endmodule

// File: rtl/dtmr_rdmux.sv
module dtmr_rdmux
   import dtmr_pkg::*;
#(
   parameter int NUM_TIMERS = 2,
   parameter int CNT_W      = 32,
   parameter int ADDR_W     = 6,
   parameter int DATA_W     = 32
) (
   input  logic [ADDR_W-1:0]                 addr,
   input  logic [2*NUM_TIMERS-1:0]           ctrl_q,
   input  logic [NUM_TIMERS-1:0][CNT_W-1:0]  rld_pk,
   input  logic [NUM_TIMERS-1:0][CNT_W-1:0]  cnt_pk,
   output logic [DATA_W-1:0]                 rd_data
);

   always_comb begin
      rd_data = '0;
      if (addr == ADDR_W'(CTRL_ADDR)) rd_data = DATA_W'(ctrl_q);
      for (int i = 0; i < NUM_TIMERS; i++) begin
         if (addr == ADDR_W'(rld_addr(i))) rd_data = DATA_W'(rld_pk[i]);
         if (addr == ADDR_W'(val_addr(i))) rd_data = DATA_W'(cnt_pk[i]);
      end
   end

endmodule

// File: rtl/dual_tmr.sv
module dual_tmr
   import dtmr_pkg::*;
#(
   parameter int NUM_TIMERS = 2,
   parameter int CNT_W      = 32,
   parameter int ADDR_W     = 6,
   parameter int DATA_W     = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick,
   input  logic [ADDR_W-1:0]     addr,
   input  logic                  wr_en,
   input  logic [DATA_W-1:0]     wr_data,
   output logic [DATA_W-1:0]     rd_data,
   output logic [NUM_TIMERS-1:0] expire_o,
   output logic                  irq_o
);

   localparam int CW       = 2 * NUM_TIMERS;
   localparam int MAP_TOP  = BANK_BASE + BANK_STEP * NUM_TIMERS;

   if (NUM_TIMERS < 1)        begin : g_chk_n   $error("NUM_TIMERS must be at least 1"); end
   if (CNT_W > DATA_W)        begin : g_chk_w   $error("CNT_W must not exceed DATA_W"); end
   if (CW > DATA_W)           begin : g_chk_c   $error("control word wider than bus"); end
   if (MAP_TOP > (1 << ADDR_W)) begin : g_chk_a $error("ADDR_W too small for register map"); end

   logic                            wr_ctrl;
   logic [NUM_TIMERS-1:0]           wr_rld;
   logic [NUM_TIMERS-1:0]           wr_val;
   logic [NUM_TIMERS-1:0]           stop_req;
   logic [CW-1:0]                   ctrl_q;
   tmr_mode_t                       mode [NUM_TIMERS];
   logic [NUM_TIMERS-1:0][CNT_W-1:0] rld_pk;
   logic [NUM_TIMERS-1:0][CNT_W-1:0] cnt_pk;

   dtmr_decode #(.NUM_TIMERS(NUM_TIMERS), .ADDR_W(ADDR_W)) u_dec (
      .addr    (addr),
      .wr_en   (wr_en),
      .wr_ctrl (wr_ctrl),
      .wr_rld  (wr_rld),
      .wr_val  (wr_val)
   );

   dtmr_ctrl #(.NUM_TIMERS(NUM_TIMERS), .DATA_W(DATA_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctrl  (wr_ctrl),
      .wr_data  (wr_data),
      .stop_req (stop_req),
      .ctrl_q   (ctrl_q),
      .mode     (mode)
   );

   for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
      dtmr_chan #(.CNT_W(CNT_W)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick     (tick),
         .mode     (mode[i]),
         .wr_rld   (wr_rld[i]),
         .wr_val   (wr_val[i]),
         .wdata    (wr_data[CNT_W-1:0]),
         .rld_q    (rld_pk[i]),
         .cnt_q    (cnt_pk[i]),
         .expire_q (expire_o[i]),
         .stop_req (stop_req[i])
      );
   end

   assign irq_o = |expire_o;

   dtmr_rdmux #(
      .NUM_TIMERS(NUM_TIMERS), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_rd (
      .addr    (addr),
      .ctrl_q  (ctrl_q),
      .rld_pk  (rld_pk),
      .cnt_pk  (cnt_pk),
      .rd_data (rd_data)
   );

endmodule

// File: rtl/dual_tmr_chk.sv
module dual_tmr_chk #(
   parameter int NUM_TIMERS = 2,
   parameter int CNT_W      = 32,
   parameter int DATA_W     = 32
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            tick,
   input logic [DATA_W-1:0]               wr_data,
   input logic                            wr_ctrl,
   input logic [NUM_TIMERS-1:0]           wr_val,
   input logic [2*NUM_TIMERS-1:0]         ctrl_q,
   input logic [NUM_TIMERS-1:0][CNT_W-1:0] rld_pk,
   input logic [NUM_TIMERS-1:0][CNT_W-1:0] cnt_pk,
   input logic [NUM_TIMERS-1:0]           expire_o
);

   p_ctrl_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> ctrl_q == $past(wr_data[2*NUM_TIMERS-1:0]));

   for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_p
      logic en, rl;
      assign en = ctrl_q[2*i];
      assign rl = ctrl_q[2*i+1];

      p_hold_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (!en && !wr_val[i]) |=> $stable(cnt_pk[i]));

      p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (en && tick && cnt_pk[i] != '0 && !wr_val[i])
            |=> cnt_pk[i] == $past(cnt_pk[i]) - 1'b1);

      p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (en && rl && tick && cnt_pk[i] == '0 && !wr_val[i])
            |=> cnt_pk[i] == $past(rld_pk[i]));

      p_oneshot_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (en && !rl && tick && cnt_pk[i] == '0 && !wr_val[i] && !wr_ctrl)
            |=> (!ctrl_q[2*i] && cnt_pk[i] == '0));

      p_write_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
         wr_val[i] |=> (cnt_pk[i] == $past(wr_data[CNT_W-1:0]) && !expire_o[i]));

      p_expire_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
         expire_o[i] |-> $past(en && tick && cnt_pk[i] == '0));
   end

endmodule

bind dual_tmr dual_tmr_chk #(
   .NUM_TIMERS(NUM_TIMERS), .CNT_W(CNT_W), .DATA_W(DATA_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .wr_data  (wr_data),
   .wr_ctrl  (wr_ctrl),
   .wr_val   (wr_val),
   .ctrl_q   (ctrl_q),
   .rld_pk   (rld_pk),
   .cnt_pk   (cnt_pk),
   .expire_o (expire_o)
);

// File: tb/dual_tmr_tb.sv
module dual_tmr_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [5:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [1:0]  expire_o;
   logic        irq_o;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;   // 50 MHz

   dual_tmr u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .expire_o(expire_o), .irq_o(irq_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] v);
      addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(6'h00, v); chk("R1 ctrl", v, 0);
      rd(6'h10, v); chk("R1 rld0", v, 0);
      rd(6'h14, v); chk("R1 cnt0", v, 0);
      rd(6'h18, v); chk("R1 rld1", v, 0);
      rd(6'h1C, v); chk("R1 cnt1", v, 0);
      chk("R1 expire", {30'd0, expire_o}, 0);
      chk("R1 irq", {31'd0, irq_o}, 0);
   endtask

   task automatic t_map;
      logic [31:0] v;
      tick = 1'b0;
      wr(6'h10, 32'h1111_1111);
      wr(6'h14, 32'h2222_2222);
      wr(6'h18, 32'h3333_3333);
      wr(6'h1C, 32'h4444_4444);
      wr(6'h00, 32'h0000_000A);
      rd(6'h10, v); chk("R3 rld0", v, 32'h1111_1111);
      rd(6'h14, v); chk("R3 cnt0", v, 32'h2222_2222);
      rd(6'h18, v); chk("R3 rld1", v, 32'h3333_3333);
      rd(6'h1C, v); chk("R3 cnt1", v, 32'h4444_4444);
      rd(6'h00, v); chk("R2 ctrl", v, 32'h0000_000A);
      rd(6'h08, v); chk("R2 unmapped 08", v, 0);
      rd(6'h04, v); chk("R2 unmapped 04", v, 0);
      wr(6'h00, 0);
   endtask

   task automatic t_hold;
      logic [31:0] v;
      tick = 1'b1;
      wr(6'h14, 5);
      repeat (4) @(negedge clk);
      rd(6'h14, v); chk("R5 disabled hold", v, 5);
      tick = 1'b0;
      wr(6'h00, 1);
      repeat (3) @(negedge clk);
      rd(6'h14, v); chk("R4 tick low hold", v, 5);
      tick = 1'b1;
      @(negedge clk); rd(6'h14, v); chk("R4 step 1", v, 4);
      @(negedge clk); rd(6'h14, v); chk("R4 step 2", v, 3);
      wr(6'h00, 0);
   endtask

   task automatic t_periodic;
      logic [31:0] v;
      tick = 1'b1;
      wr(6'h10, 3);
      wr(6'h14, 3);
      wr(6'h00, 3);
      for (int c = 1; c <= 9; c++) begin
         @(negedge clk);
         rd(6'h14, v);
         chk("R6 periodic count", v, 32'(3 - (c % 4)));
         chk("R8 expire0", {31'd0, expire_o[0]}, 32'((c % 4) == 0));
         chk("R8 irq", {31'd0, irq_o}, 32'((c % 4) == 0));
      end
      wr(6'h00, 0);
   endtask

   task automatic t_oneshot;
      logic [31:0] v;
      tick = 1'b1;
      wr(6'h1C, 2);
      wr(6'h00, 4);
      for (int c = 1; c <= 5; c++) begin
         @(negedge clk);
         rd(6'h1C, v);
         chk("R7 oneshot count", v, (c == 1) ? 1 : 0);
         chk("R7 single expire1", {31'd0, expire_o[1]}, 32'(c == 3));
         rd(6'h00, v);
         chk("R7 enable self-clear", v, (c >= 3) ? 0 : 4);
      end
      wr(6'h00, 0);
   endtask

   task automatic t_write_first;
      logic [31:0] v;
      tick = 1'b1;
      wr(6'h14, 0);
      wr(6'h10, 50);
      wr(6'h00, 3);
      wr(6'h14, 7);
      rd(6'h14, v); chk("R9 write beats reload", v, 7);
      chk("R9 no expire", {31'd0, expire_o[0]}, 0);
      @(negedge clk);
      rd(6'h14, v); chk("R9 counts from written", v, 6);
      wr(6'h00, 0);
   endtask

   task automatic t_ctrl_first;
      logic [31:0] v;
      tick = 1'b1;
      wr(6'h14, 0);
      wr(6'h00, 1);
      wr(6'h00, 1);
      rd(6'h00, v); chk("R11 write beats self-clear", v, 1);
      chk("R11 expire still", {31'd0, expire_o[0]}, 1);
      @(negedge clk);
      rd(6'h00, v); chk("R11 later self-clear", v, 0);
      chk("R11 second expire", {31'd0, expire_o[0]}, 1);
      @(negedge clk);
      chk("R11 quiet after stop", {31'd0, expire_o[0]}, 0);
   endtask

   task automatic t_shared;
      logic [31:0] v0, v;
      tick = 1'b1;
      wr(6'h10, 1000);
      wr(6'h14, 1000);
      wr(6'h00, 3);
      rd(6'h14, v0);
      wr(6'h00, 7);
      wr(6'h00, 3);
      rd(6'h14, v); chk("R10 timer0 undisturbed", v, v0 - 2);
      rd(6'h00, v); chk("R10 ctrl readback", v, 3);
      wr(6'h00, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_map;
      t_hold;
      t_periodic;
      t_oneshot;
      t_write_first;
      t_ctrl_first;
      t_shared;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule